// File: doc/BRIEF.md
# Bit-Sliced ALU with Signed-Overflow Trap

This block is the integer arithmetic and logic unit of a 32-bit processor datapath. A chain of identical one-bit slices computes AND, OR, NOR or an adder sum of two operands. A per-slice multiplexer picks the output of each slice, and the carry ripples from the lowest slice to the highest. A subtract control inverts operand B and feeds a carry-in of one, so the adder forms A minus B as A plus the two's complement of B. The result, a zero flag, the carry out of the top slice and a signed-overflow flag are all combinational.

A small registered path sits next to the datapath. When a valid operation that the issuing stage marks as signed (a trapping add, add-immediate or subtract) overflows, the block raises a trap in the same cycle. On the next rising clock edge it copies that operation's program counter into an exception PC register. Unsigned variants compute the same flags but never trap.

Top module: `alu_trap_top`

## Requirements
- R1: With `op_sel` 0 the result is A AND B', with 1 it is A OR B', with 3 it is NOR of A and B'. B' is B when `sub_en` is 0 and the bitwise inverse of B when `sub_en` is 1.
- R2: With `op_sel` 2 the result is the low 32 bits of A + B' + `sub_en`. With `sub_en` = 1 this equals A − B modulo 2^32.
- R3: In adder mode, `overflow` is 1 exactly when A[31] equals B'[31] and result[31] differs from A[31].
- R4: In adder mode, `carry_out` is the carry out of bit 31 of A + B' + `sub_en`. For a subtract this is 1 exactly when A ≥ B as unsigned numbers.
- R5: For AND, OR and NOR, `carry_out` and `overflow` are both 0.
- R6: `zero` is 1 exactly when all 32 result bits are 0, for every operation.
- R7: When `op_valid`, `signed_op` and `overflow` are all 1, `trap` is 1 in the same cycle, and `epc` holds that cycle's `op_pc` after the next rising clock edge.
- R8: When `signed_op` is 0, `op_valid` is 0 or `overflow` is 0, `trap` is 0 and `epc` keeps its value across the clock edge, even when an unsigned operation overflows.
- R9: With `rst` high at a rising clock edge, `epc` becomes 0 (synchronous reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the exception PC register |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | The operation this cycle is real |
| op_sel | input | 2 | 0 AND, 1 OR, 2 adder sum, 3 NOR |
| sub_en | input | 1 | Invert B and set carry-in to one |
| signed_op | input | 1 | Operation traps on overflow |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| op_pc | input | 32 | Program counter of the operation |
| result | output | 32 | Selected slice outputs |
| zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Carry out of the top slice in adder mode |
| overflow | output | 1 | Signed overflow in adder mode |
| trap | output | 1 | Trapping overflow this cycle |
| epc | output | 32 | Exception program counter |

## Verification
The result, the three flags and `trap` are combinational, so each is due in the same cycle as its operands. The bench drives operands on the falling edge and samples a short delay later, before the next rising edge. `epc` is due one rising edge after the trapping operation. The bench applies that operation on a falling edge, lets one rising edge pass and reads `epc` at the next falling edge. Reset is checked the same way, one edge after `rst` is raised.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned PC_W   = 32;

    typedef enum logic [1:0] {
        OP_AND = 2'd0,
        OP_OR  = 2'd1,
        OP_SUM = 2'd2,
        OP_NOR = 2'd3
    } alu_op_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    binv_i,
    input  logic    cin_i,
    input  alu_op_e op_i,
    output logic    sum_o,
    output logic    res_o,
    output logic    cout_o
);
    logic b_eff;
    logic prop;

    always_comb begin
        b_eff  = b_i ^ binv_i;
        prop   = a_i ^ b_eff;
        sum_o  = prop ^ cin_i;
        cout_o = (a_i & b_eff) | (cin_i & prop);
        unique case (op_i)
            OP_AND:  res_o = a_i & b_eff;
            OP_OR:   res_o = a_i | b_eff;
            OP_SUM:  res_o = sum_o;
            default: res_o = ~(a_i | b_eff);
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             a_msb_i,
    input  logic             b_msb_eff_i,
    input  logic             sum_msb_i,
    input  logic             carry_top_i,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);
    logic is_sum;

    always_comb begin
        is_sum  = (op_i == OP_SUM);
        zero_o  = ~|res_i;
        carry_o = is_sum & carry_top_i;
        ovf_o   = is_sum & (a_msb_i == b_msb_eff_i) & (sum_msb_i != a_msb_i);
    end
endmodule

// File: rtl/alu_epc_reg.sv
module alu_epc_reg
    import alu_pkg::*;
#(
    parameter int unsigned ADDR_W = PC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] epc_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] epc;
    } epc_state_t;

    epc_state_t state_d;
    epc_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.epc = pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign epc_o = state_q.epc;
endmodule

// File: rtl/alu_trap_top.sv
module alu_trap_top
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH  = DATA_W,
    parameter int unsigned ADDR_W = PC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic              sub_en,
    input  logic              signed_op,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic [ADDR_W-1:0] op_pc,
    output logic [WIDTH-1:0]  result,
    output logic              zero,
    output logic              carry_out,
    output logic              overflow,
    output logic              trap,
    output logic [ADDR_W-1:0] epc
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_bits;

    assign op       = alu_op_e'(op_sel);
    assign carry[0] = sub_en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_i    (a[i]),
            .b_i    (b[i]),
            .binv_i (sub_en),
            .cin_i  (carry[i]),
            .op_i   (op),
            .sum_o  (sum_bits[i]),
            .res_o  (result[i]),
            .cout_o (carry[i+1])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .op_i        (op),
        .res_i       (result),
        .a_msb_i     (a[MSB]),
        .b_msb_eff_i (b[MSB] ^ sub_en),
        .sum_msb_i   (sum_bits[MSB]),
        .carry_top_i (carry[WIDTH]),
        .zero_o      (zero),
        .carry_o     (carry_out),
        .ovf_o       (overflow)
    );

    assign trap = op_valid & signed_op & overflow;

    alu_epc_reg #(.ADDR_W(ADDR_W)) u_epc (
        .clk    (clk),
        .rst    (rst),
        .load_i (trap),
        .pc_i   (op_pc),
        .epc_o  (epc)
    );
endmodule

// File: rtl/alu_trap_chk.sv
module alu_trap_chk #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_sel,
    input logic              sub_en,
    input logic              signed_op,
    input logic [WIDTH-1:0]  a,
    input logic [WIDTH-1:0]  b,
    input logic [ADDR_W-1:0] op_pc,
    input logic [WIDTH-1:0]  result,
    input logic              carry_out,
    input logic              overflow,
    input logic              trap,
    input logic [ADDR_W-1:0] epc
);
    AST_LOGIC_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_sel != 2'd2) |-> (!carry_out && !overflow)); // R5

    AST_OVF_SIGNS: assert property (@(posedge clk) disable iff (rst)
        overflow |-> ((a[WIDTH-1] == (b[WIDTH-1] ^ sub_en)) && (result[WIDTH-1] != a[WIDTH-1]))); // R3

    AST_EPC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && signed_op && overflow) |=> (epc == $past(op_pc))); // R7

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && signed_op && overflow) |=> $stable(epc)); // R8

    AST_UNSIGNED_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        !signed_op |-> !trap); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (epc == '0)); // R9
endmodule

bind alu_trap_top alu_trap_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .sub_en    (sub_en),
    .signed_op (signed_op),
    .a         (a),
    .b         (b),
    .op_pc     (op_pc),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .trap      (trap),
    .epc       (epc)
);

// File: tb/tb_alu_trap_top.sv
module tb_alu_trap_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_sel;
    logic        sub_en;
    logic        signed_op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] op_pc;
    logic [31:0] result;
    logic        zero;
    logic        carry_out;
    logic        overflow;
    logic        trap;
    logic [31:0] epc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu_trap_top dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .sub_en(sub_en), .signed_op(signed_op), .a(a), .b(b), .op_pc(op_pc),
        .result(result), .zero(zero), .carry_out(carry_out),
        .overflow(overflow), .trap(trap), .epc(epc)
    );

    // vector: {op_sel[2], sub_en[1], a[32], b[32]}
    localparam int NV = 14;
    localparam logic [66:0] VEC [NV] = '{
        {2'd0, 1'b0, 32'hFFFF0000, 32'h0FF00FF0},
        {2'd1, 1'b0, 32'hFFFF0000, 32'h0FF00FF0},
        {2'd3, 1'b0, 32'hFFFF0000, 32'h0FF00FF0},
        {2'd2, 1'b0, 32'h00000007, 32'h00000006},
        {2'd2, 1'b1, 32'h00000007, 32'h00000006},
        {2'd2, 1'b0, 32'h7FFFFFFF, 32'h00000001},
        {2'd2, 1'b0, 32'h80000000, 32'h80000000},
        {2'd2, 1'b1, 32'h80000000, 32'h00000001},
        {2'd2, 1'b1, 32'h00000005, 32'h00000005},
        {2'd2, 1'b0, 32'hFFFFFFFF, 32'h00000001},
        {2'd0, 1'b1, 32'hFFFFFFFF, 32'h0000FFFF},
        {2'd2, 1'b1, 32'h00000000, 32'h80000000},
        {2'd3, 1'b0, 32'h00000000, 32'h00000000},
        {2'd1, 1'b0, 32'h00000000, 32'h00000000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic s, input logic [31:0] av,
                         input logic [31:0] bv, input logic v, input logic sg, input logic [31:0] pc);
        @(negedge clk);
        op_sel = op; sub_en = s; a = av; b = bv; op_valid = v; signed_op = sg; op_pc = pc;
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_sel = 2'd0; sub_en = 1'b0;
        signed_op = 1'b0; a = '0; b = '0; op_pc = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(epc == 32'h0, "R9 reset epc", epc, 32'h0);
        rst = 1'b0;

        // table walk: combinational results, model from R1..R6
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic        s;
            logic [31:0] av, bv, bb, er;
            logic [32:0] full;
            logic        ec, ev;
            {op, s, av, bv} = VEC[i];
            bb   = s ? ~bv : bv;
            full = {1'b0, av} + {1'b0, bb} + {32'd0, s};
            case (op)
                2'd0:    er = av & bb;
                2'd1:    er = av | bb;
                2'd2:    er = full[31:0];
                default: er = ~(av | bb);
            endcase
            ec = (op == 2'd2) ? full[32] : 1'b0;
            ev = (op == 2'd2) ? ((av[31] == bb[31]) && (full[31] != av[31])) : 1'b0;
            drive(op, s, av, bv, 1'b0, 1'b0, 32'h0);
            check(result == er, (op == 2'd2) ? "R2 sum result" : "R1 logic result", result, er);
            check(overflow == ev, (op == 2'd2) ? "R3 overflow" : "R5 overflow", {31'd0, overflow}, {31'd0, ev});
            check(carry_out == ec, (op == 2'd2) ? "R4 carry" : "R5 carry", {31'd0, carry_out}, {31'd0, ec});
            check(zero == (er == 32'h0), "R6 zero", {31'd0, zero}, {31'd0, er == 32'h0});
        end

        // R7: signed add overflow traps and loads epc
        drive(2'd2, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1, 32'h00000400);
        check(trap == 1'b1, "R7 trap same cycle", {31'd0, trap}, 32'd1);
        @(negedge clk);
        check(epc == 32'h00000400, "R7 epc loaded", epc, 32'h00000400);

        // R8: unsigned overflow does not trap
        drive(2'd2, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b0, 32'h00000500);
        check(trap == 1'b0, "R8 unsigned no trap", {31'd0, trap}, 32'd0);
        check(overflow == 1'b1, "R8 unsigned ovf flag", {31'd0, overflow}, 32'd1);
        @(negedge clk);
        check(epc == 32'h00000400, "R8 epc held unsigned", epc, 32'h00000400);

        // R8: signed overflow but invalid op
        drive(2'd2, 1'b1, 32'h80000000, 32'h00000001, 1'b0, 1'b1, 32'h00000600);
        check(trap == 1'b0, "R8 invalid no trap", {31'd0, trap}, 32'd0);
        @(negedge clk);
        check(epc == 32'h00000400, "R8 epc held invalid", epc, 32'h00000400);

        // R8: signed without overflow
        drive(2'd2, 1'b1, 32'h00000009, 32'h00000002, 1'b1, 1'b1, 32'h00000700);
        @(negedge clk);
        check(epc == 32'h00000400, "R8 epc held no ovf", epc, 32'h00000400);

        // R7: signed subtract overflow
        drive(2'd2, 1'b1, 32'h80000000, 32'h00000001, 1'b1, 1'b1, 32'h00000800);
        check(trap == 1'b1, "R7 sub trap", {31'd0, trap}, 32'd1);
        @(negedge clk);
        check(epc == 32'h00000800, "R7 epc sub", epc, 32'h00000800);

        // R9: reset clears epc
        drive(2'd0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        check(epc == 32'h0, "R9 reset clears", epc, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule